// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts hardware activity for one processor core. It holds one cycle counter and a parameterised number of event counters (four by default). Each event counter is bound to one of 256 event codes through its own 8-bit type field. It advances on every clock in which the event line picked by that code is high. The cycle counter advances on every enabled clock, or once per 64 enabled clocks when the prescale mode is on.

Software reaches the unit through a plain synchronous register port with address, write strobe, write data and read data. Read data is registered and appears one clock after the address is presented. The event counters have no addresses of their own: a select register names one counter, and two windows read or write that counter's value and event type. Count enables and interrupt enables each use a set register and a clear register. Overflow flags are cleared by writing a one. A single interrupt line combines every flagged counter whose interrupt is enabled.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, every counter, enable mask, interrupt mask, overflow flag and the interrupt line are 0. The control register (offset 0x00) reads back bits 0, 3, 4 and 5 as written. Bits 1 and 2 read as 0, and bits 15:11 report the number of event counters (4 by default), so writing 0x3F reads back 0x2039.
- R2: Control bit 0 is the global run bit. While it is 0 no counter advances, whatever the inputs do.
- R3: Event counter i advances by one on each clock in which the run bit is set, its enable bit i is set and event input bit `type_i` is 1. `type_i` is the 8-bit code written through the event-type window (0x1C) while the select register holds i, and that window reads the code back.
- R4: Count enables use offsets 0x04 (set) and 0x08 (clear). A 1 in bit i (event counter i, i < 4) or bit 31 (cycle counter) of the write data sets or clears that enable. Zero bits leave their enable unchanged, and both offsets read back the current enable mask.
- R5: A control write with bit 1 set zeroes all event counters. A control write with bit 2 set zeroes the cycle counter and its prescaler.
- R6: The cycle counter (offset 0x18) is read and written directly. It advances once per clock while the run bit and enable bit 31 are set.
- R7: With control bit 3 set, the cycle counter advances once per 64 enabled clocks (128 enabled clocks from zero give 2).
- R8: A counter stepping from 0xFFFFFFFF to 0 sets its overflow flag (bit i or bit 31 of offset 0x0C). Writing a 1 to a flag bit clears it, zero bits leave flags alone, and a new overflow wins over a clear in the same clock.
- R9: The interrupt output is registered. It equals the OR over all counters of (overflow flag AND interrupt enable) as those stood one clock earlier.
- R10: Interrupt enables use offsets 0x24 (set) and 0x28 (clear), with the same bit layout and set/clear semantics as R4. Both offsets read back the interrupt mask.
- R11: The select register (offset 0x14) holds a 5-bit index and reads back as written. When the index is 4 or more, reads of the count window (0x20) and the event-type window return 0, and writes to those windows change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe for the current clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous clock |
| evt_in | input | 256 | One-cycle event pulses, one bit per event code |
| irq_out | output | 1 | Combined overflow interrupt |

## Verification
The assertions take for granted that the bus writes at most one register per clock. They also assume event pulses last a single clock, and that the interface supplies only the defined offsets. Under those conditions the enable, wrap and interrupt relations hold every clock. The stimulus keeps to this by driving each write as a single one-clock strobe at the falling edge and dropping every event pulse after one clock. It also avoids the undefined offset 0x10. Counting windows are opened and closed by control writes a fixed number of clocks apart, so the expected cycle totals follow from counting edges.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int CYC_BIT = 31;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_ENSET  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_ENCLR  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_FLAGS  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_SEL    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CYC    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_TYPE   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_VALUE  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_IESET  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_IECLR  = 8'h28;

  // control bit positions
  localparam int CB_RUN   = 0;
  localparam int CB_ZEV   = 1;
  localparam int CB_ZCY   = 2;
  localparam int CB_DIV   = 3;
  localparam int CTRL_W   = 6;
  localparam int NFLD_LSB = 11;
  localparam int NFLD_W   = 5;
endpackage

// File: rtl/pmu_event_counter.sv
module pmu_event_counter #(
  parameter int DATA_W = 32,
  parameter int CODE_W = 8,
  localparam int NUM_EVT = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic              run,
  input  logic              zero,
  input  logic              wr_type,
  input  logic              wr_val,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value,
  output logic [CODE_W-1:0] code,
  output logic              wrap
);
  logic [DATA_W-1:0] val_q;
  logic [CODE_W-1:0] code_q;
  logic              step;

  assign step  = run & evt_in[code_q];
  assign wrap  = step & (&val_q) & ~zero & ~wr_val;
  assign value = val_q;
  assign code  = code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q  <= '0;
      code_q <= '0;
    end else begin
      if (zero)        val_q <= '0;
      else if (wr_val) val_q <= wdata;
      else if (step)   val_q <= val_q + 1'b1;
      if (wr_type)     code_q <= wdata[CODE_W-1:0];
    end
  end
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter #(
  parameter int DATA_W   = 32,
  parameter int DIV_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              div_mode,
  input  logic              zero,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value,
  output logic              wrap
);
  logic [DATA_W-1:0]   val_q;
  logic [DIV_LOG2-1:0] pre_q;
  logic                step;

  assign step  = run & (~div_mode | (&pre_q));
  assign wrap  = step & (&val_q) & ~zero & ~wr;
  assign value = val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      pre_q <= '0;
    end else if (zero) begin
      val_q <= '0;
      pre_q <= '0;
    end else begin
      if (wr)        val_q <= wdata;
      else if (step) val_q <= val_q + 1'b1;
      if (run && div_mode) pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit #(
  parameter int NUM_CNT  = 4,
  parameter int CODE_W   = 8,
  parameter int SEL_W    = 5,
  parameter int DIV_LOG2 = 6,
  localparam int NUM_EVT = 1 << CODE_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [pmu_pkg::ADDR_W-1:0]  bus_addr,
  input  logic                        bus_we,
  input  logic [pmu_pkg::DATA_W-1:0]  bus_wdata,
  output logic [pmu_pkg::DATA_W-1:0]  bus_rdata,
  input  logic [NUM_EVT-1:0]          evt_in,
  output logic                        irq_out
);
  import pmu_pkg::*;

  localparam logic [DATA_W-1:0] IMPL =
    (DATA_W'(1) << CYC_BIT) | ((DATA_W'(1) << NUM_CNT) - 1'b1);
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 6'b111001;

  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] en_q, ie_q, ovf_q, rdata_q;
  logic [SEL_W-1:0]  sel_q;
  logic              irq_q;

  logic w_ctrl, w_enset, w_enclr, w_flags, w_sel, w_cyc, w_type, w_val, w_ieset, w_ieclr;
  assign w_ctrl  = bus_we && bus_addr == OFS_CTRL;
  assign w_enset = bus_we && bus_addr == OFS_ENSET;
  assign w_enclr = bus_we && bus_addr == OFS_ENCLR;
  assign w_flags = bus_we && bus_addr == OFS_FLAGS;
  assign w_sel   = bus_we && bus_addr == OFS_SEL;
  assign w_cyc   = bus_we && bus_addr == OFS_CYC;
  assign w_type  = bus_we && bus_addr == OFS_TYPE;
  assign w_val   = bus_we && bus_addr == OFS_VALUE;
  assign w_ieset = bus_we && bus_addr == OFS_IESET;
  assign w_ieclr = bus_we && bus_addr == OFS_IECLR;

  logic [DATA_W-1:0] ev_val  [NUM_CNT];
  logic [CODE_W-1:0] ev_code [NUM_CNT];
  logic [DATA_W-1:0] wrap_vec;
  logic [DATA_W-1:0] cyc_val;
  logic              cyc_wrap;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CNT; gi++) begin : g_evc
      logic hit_sel;
      assign hit_sel = (sel_q == SEL_W'(gi));
      pmu_event_counter #(.DATA_W(DATA_W), .CODE_W(CODE_W)) evc_i (
        .clk     (clk),
        .rst     (rst),
        .evt_in  (evt_in),
        .run     (ctrl_q[CB_RUN] & en_q[gi]),
        .zero    (w_ctrl & bus_wdata[CB_ZEV]),
        .wr_type (w_type & hit_sel),
        .wr_val  (w_val & hit_sel),
        .wdata   (bus_wdata),
        .value   (ev_val[gi]),
        .code    (ev_code[gi]),
        .wrap    (wrap_vec[gi])
      );
    end
    for (gi = NUM_CNT; gi < DATA_W; gi++) begin : g_nowrap
      if (gi == CYC_BIT) begin : g_cyc
        assign wrap_vec[gi] = cyc_wrap;
      end else begin : g_zero
        assign wrap_vec[gi] = 1'b0;
      end
    end
  endgenerate

  pmu_cycle_counter #(.DATA_W(DATA_W), .DIV_LOG2(DIV_LOG2)) cyc_i (
    .clk      (clk),
    .rst      (rst),
    .run      (ctrl_q[CB_RUN] & en_q[CYC_BIT]),
    .div_mode (ctrl_q[CB_DIV]),
    .zero     (w_ctrl & bus_wdata[CB_ZCY]),
    .wr       (w_cyc),
    .wdata    (bus_wdata),
    .value    (cyc_val),
    .wrap     (cyc_wrap)
  );

  // indirect window read data
  logic [DATA_W-1:0] win_val;
  logic [CODE_W-1:0] win_code;
  always_comb begin
    win_val  = '0;
    win_code = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (sel_q == SEL_W'(i)) begin
        win_val  = ev_val[i];
        win_code = ev_code[i];
      end
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_CTRL: begin
        rd_mux[CTRL_W-1:0] = ctrl_q;
        rd_mux[NFLD_LSB +: NFLD_W] = NFLD_W'(NUM_CNT);
      end
      OFS_ENSET, OFS_ENCLR: rd_mux = en_q;
      OFS_IESET, OFS_IECLR: rd_mux = ie_q;
      OFS_FLAGS: rd_mux = ovf_q;
      OFS_SEL:   rd_mux[SEL_W-1:0] = sel_q;
      OFS_CYC:   rd_mux = cyc_val;
      OFS_TYPE:  rd_mux[CODE_W-1:0] = win_code;
      OFS_VALUE: rd_mux = win_val;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      en_q    <= '0;
      ie_q    <= '0;
      ovf_q   <= '0;
      sel_q   <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (w_ctrl)  ctrl_q <= bus_wdata[CTRL_W-1:0] & CTRL_KEEP;
      if (w_enset) en_q <= en_q | (bus_wdata & IMPL);
      if (w_enclr) en_q <= en_q & ~(bus_wdata & IMPL);
      if (w_ieset) ie_q <= ie_q | (bus_wdata & IMPL);
      if (w_ieclr) ie_q <= ie_q & ~(bus_wdata & IMPL);
      if (w_sel)   sel_q <= bus_wdata[SEL_W-1:0];
      ovf_q   <= (ovf_q & ~(w_flags ? (bus_wdata & IMPL) : '0)) | wrap_vec;
      rdata_q <= rd_mux;
      irq_q   <= |(ovf_q & ie_q);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int NUM_CNT = 4
) (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  bus_addr,
  input logic        bus_we,
  input logic [31:0] bus_wdata,
  input logic [5:0]  ctrl_q,
  input logic [31:0] en_q,
  input logic [31:0] ie_q,
  input logic [31:0] ovf_q,
  input logic [31:0] cyc_val,
  input logic        irq_out
);
  localparam logic [31:0] IMPL = (32'd1 << 31) | ((32'd1 << NUM_CNT) - 1);

  logic touch_cyc;
  assign touch_cyc = bus_we && (bus_addr == 8'h18 || bus_addr == 8'h00);

  assert_irq_combine_R9: assert property (@(posedge clk) disable iff (rst)
    irq_out == $past(|(ovf_q & ie_q)));

  assert_run_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[0] && !touch_cyc) |=> cyc_val == $past(cyc_val));

  assert_wrap_flag_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q[31]) |-> cyc_val == 32'd0);

  assert_en_set_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 8'h04) |=> ((en_q & $past(bus_wdata & IMPL)) == $past(bus_wdata & IMPL)));

  assert_en_clr_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 8'h08) |=> ((en_q & $past(bus_wdata & IMPL)) == 32'd0));

  assert_ie_clr_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 8'h28) |=> ((ie_q & $past(bus_wdata & IMPL)) == 32'd0));

  assert_cyc_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 8'h00 && bus_wdata[2]) |=> cyc_val == 32'd0);
endmodule

bind perf_mon_unit pmu_checker #(.NUM_CNT(NUM_CNT)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .ctrl_q    (ctrl_q),
  .en_q      (en_q),
  .ie_q      (ie_q),
  .ovf_q     (ovf_q),
  .cyc_val   (cyc_val),
  .irq_out   (irq_out)
);

// File: tb/perf_mon_unit_tb_top.sv
module perf_mon_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [255:0] evt_in = '0;
  logic         irq_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  perf_mon_unit dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq_out(irq_out)
  );

  localparam logic [7:0] CTRL = 8'h00, ENS = 8'h04, ENC = 8'h08, FLG = 8'h0C,
    SEL = 8'h14, CYC = 8'h18, TYP = 8'h1C, VAL = 8'h20, IES = 8'h24, IEC = 8'h28;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [255:0] v);
    @(negedge clk);
    evt_in = v;
    @(negedge clk);
    evt_in = '0;
  endtask

  function automatic logic [7:0] code_of(input int i);
    return 8'(8'h10 + i * 8'h31);
  endfunction

  task automatic rd_cnt(input int i, output logic [31:0] d);
    wr(SEL, 32'(i));
    rd(VAL, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] exp_cnt [4];
    logic [255:0] all_ev;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(CTRL, d); chk("R1 ctrl reset", d, 32'h0000_2000);
    rd(ENS, d);  chk("R1 enable reset", d, 0);
    rd(FLG, d);  chk("R1 flags reset", d, 0);
    rd(CYC, d);  chk("R1 cycle reset", d, 0);
    chk("R1 irq reset", {31'b0, irq_out}, 0);
    wr(CTRL, 32'h3F); rd(CTRL, d); chk("R1 ctrl writable bits", d, 32'h0000_2039);
    wr(CTRL, 32'hFFFF_FFC0); rd(CTRL, d); chk("R1 ctrl upper bits ignored", d, 32'h0000_2000);

    // R3 event type programming and sweep
    all_ev = '0;
    for (int i = 0; i < 4; i++) begin
      wr(SEL, 32'(i)); wr(TYP, {24'hABCDEF, code_of(i)});
      all_ev[code_of(i)] = 1'b1;
    end
    for (int i = 0; i < 4; i++) begin
      wr(SEL, 32'(i)); rd(TYP, d); chk("R3 type readback", d, {24'h0, code_of(i)});
      exp_cnt[i] = 0;
    end
    wr(ENS, 32'h0000_000F);
    rd(ENC, d); chk("R4 enable mask via clear offset", d, 32'h0000_000F);
    wr(CTRL, 32'h1);
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < i + 2; k++) begin
        logic [255:0] v;
        v = '0; v[code_of(i)] = 1'b1;
        pulse(v);
        exp_cnt[i]++;
      end
      pulse(256'(1) << 8'h05); // unmapped code
    end
    pulse(all_ev);
    for (int i = 0; i < 4; i++) exp_cnt[i]++;
    wr(CTRL, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd_cnt(i, d); chk("R3 event count", d, exp_cnt[i]);
    end

    // R2 global run bit off
    pulse(all_ev); pulse(all_ev);
    for (int i = 0; i < 4; i++) begin
      rd_cnt(i, d); chk("R2 no count while stopped", d, exp_cnt[i]);
    end

    // R4 enable clear and zero-bit writes
    wr(ENC, 32'h0000_0004);
    wr(ENS, 32'h0); wr(ENC, 32'h0);
    rd(ENS, d); chk("R4 zero bits ignored", d, 32'h0000_000B);
    wr(CTRL, 32'h1); pulse(all_ev); wr(CTRL, 32'h0);
    for (int i = 0; i < 4; i++) begin
      if (i != 2) exp_cnt[i]++;
      rd_cnt(i, d); chk("R4 per-counter enable", d, exp_cnt[i]);
    end

    // R11 select out of range
    wr(SEL, 32'h7); wr(VAL, 32'h55); wr(TYP, 32'h22);
    rd(SEL, d); chk("R11 select readback", d, 32'h7);
    rd(VAL, d); chk("R11 value window reads 0", d, 0);
    rd(TYP, d); chk("R11 type window reads 0", d, 0);
    for (int i = 0; i < 4; i++) begin
      rd_cnt(i, d); chk("R11 writes ignored value", d, exp_cnt[i]);
      rd(TYP, d); chk("R11 writes ignored type", d, {24'h0, code_of(i)});
    end

    // R5 zero all event counters
    wr(CTRL, 32'h2);
    for (int i = 0; i < 4; i++) begin
      rd_cnt(i, d); chk("R5 event counters zeroed", d, 0);
    end

    // R8 / R9 / R10 event counter overflow
    wr(SEL, 32'h0); wr(VAL, 32'hFFFF_FFFE);
    wr(IES, 32'h0000_0001);
    rd(IEC, d); chk("R10 interrupt mask readback", d, 32'h1);
    wr(CTRL, 32'h1);
    begin
      logic [255:0] v;
      v = '0; v[code_of(0)] = 1'b1;
      pulse(v);
      chk("R9 no irq before wrap", {31'b0, irq_out}, 0);
      pulse(v);
    end
    wr(CTRL, 32'h0);
    rd(VAL, d); chk("R8 counter wrapped", d, 0);
    rd(FLG, d); chk("R8 flag set", d, 32'h1);
    chk("R9 irq raised", {31'b0, irq_out}, 1);
    wr(FLG, 32'h0);
    rd(FLG, d); chk("R8 zero write keeps flag", d, 32'h1);
    wr(FLG, 32'h1);
    @(negedge clk);
    chk("R9 irq dropped after clear", {31'b0, irq_out}, 0);
    rd(FLG, d); chk("R8 flag cleared", d, 0);

    // R6 cycle counter
    wr(CYC, 32'h1234_5678); rd(CYC, d); chk("R6 cycle direct write", d, 32'h1234_5678);
    wr(CTRL, 32'h4); rd(CYC, d); chk("R5 cycle zeroed", d, 0);
    wr(ENS, 32'h8000_0000);
    wr(CTRL, 32'h1); repeat (20) @(negedge clk); wr(CTRL, 32'h0);
    rd(CYC, d); chk("R6 cycle count", d, 32'd22);
    wr(CTRL, 32'h1); repeat (5) @(negedge clk); wr(CTRL, 32'h0);
    rd(CYC, d); chk("R6 cycle accumulates", d, 32'd29);

    // R7 prescale
    wr(CTRL, 32'h4);
    wr(CTRL, 32'h9); repeat (126) @(negedge clk); wr(CTRL, 32'h8);
    rd(CYC, d); chk("R7 divide by 64", d, 32'd2);
    wr(CTRL, 32'h4);
    wr(CTRL, 32'h9); repeat (60) @(negedge clk); wr(CTRL, 32'h8);
    rd(CYC, d); chk("R7 below one period", d, 32'd0);

    // R8 / R10 cycle overflow
    wr(CTRL, 32'h0);
    wr(CYC, 32'hFFFF_FFF0);
    wr(CTRL, 32'h1); repeat (14) @(negedge clk); wr(CTRL, 32'h0);
    rd(CYC, d); chk("R8 cycle wrapped", d, 0);
    rd(FLG, d); chk("R8 cycle flag bit 31", d, 32'h8000_0000);
    chk("R9 masked flag gives no irq", {31'b0, irq_out}, 0);
    wr(IES, 32'h8000_0000);
    @(negedge clk);
    chk("R10 irq after enable set", {31'b0, irq_out}, 1);
    wr(IEC, 32'h8000_0000);
    @(negedge clk);
    chk("R10 irq after enable clear", {31'b0, irq_out}, 0);
    rd(IES, d); chk("R10 mask after clear", d, 32'h1);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule